// File: doc/BRIEF.md
# Receive Buffer with Hardware Handshake Gating

This block holds bytes arriving from a serial receiver until a downstream consumer takes them, and it handles both directions of hardware handshake on the serial link. On the receive side it stores bytes in first-in, first-out order. It raises an active-low request-to-send line to ask the far end to pause once the stored count crosses a fixed mark. On the transmit side it gates a per-byte request/grant handshake with the active-low clear-to-send input from the far end. After that input goes inactive, only a bounded number of further bytes may start.

The receiver writes one byte per cycle with a valid strobe. The consumer reads through a ready/valid port, and the current fill count is visible at all times. An enable input switches the handshake pins on or off. A flush input empties the buffer, clears the overflow flag and resets the transmit-side slip allowance. The default sizing is a 576-byte buffer with the pause mark at 383 bytes and a slip allowance of two bytes.

Top module: `rx_flow_buffer`

## Requirements
- R1: After reset the fill level is 0, `rdValid` is 0, `overflow` is 0 and `rtsN` is 0.
- R2: Bytes leave the read port in the order they were accepted. `rdValid` is 1 exactly when the fill level is nonzero, and `rdData` shows the oldest stored byte.
- R3: With `hwFlowEn` = 1, `rtsN` is 1 whenever the fill level is at or above WATERMARK (default 383). It changes in the same cycle the level register reaches that value.
- R4: `rtsN` returns to 0 in the same cycle the level falls below WATERMARK. There is no hysteresis.
- R5: The buffer holds DEPTH bytes (default 576). A write while full, with no read in the same cycle, is dropped, leaves the level unchanged, and sets `overflow`. `overflow` stays set until a flush.
- R6: A read and a write in the same cycle leave the fill level unchanged, even when the buffer is full. That case is not an overflow.
- R7: With `hwFlowEn` = 1 and `ctsN` = 1, at most SLIP grants (default 2) are given after `ctsN` went high. Further requests get `txGrant` = 0 until `ctsN` returns to 0.
- R8: With `hwFlowEn` = 1 and `ctsN` = 0, `txGrant` equals `txReq` in the same cycle.
- R9: With `hwFlowEn` = 0, `rtsN` stays 0 at any fill level, and `ctsN` is ignored, so `txGrant` equals `txReq`.
- R10: A cycle with `flush` = 1 leaves the level at 0 and `overflow` at 0, and resets the slip allowance to its full SLIP grants. A write in that cycle is discarded without setting `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hwFlowEn | input | 1 | Enables the request-to-send and clear-to-send handshake |
| flush | input | 1 | Empties the buffer, clears overflow, resets slip allowance |
| wrValid | input | 1 | Receiver byte strobe |
| wrData | input | DATA_W | Received byte |
| rdValid | output | 1 | Buffer holds at least one byte |
| rdReady | input | 1 | Consumer takes the oldest byte |
| rdData | output | DATA_W | Oldest stored byte |
| fillLevel | output | clog2(DEPTH+1) | Number of stored bytes |
| overflow | output | 1 | Sticky flag: a byte was dropped while full |
| rtsN | output | 1 | Request-to-send, active low |
| ctsN | input | 1 | Clear-to-send from far end, active low |
| txReq | input | 1 | Transmitter asks to start a byte |
| txGrant | output | 1 | Transmitter may start the byte this cycle |

## Verification
The bench builds the block with DEPTH = 6, WATERMARK = 4 and SLIP = 2. With these values a handful of writes reaches the pause mark, fills the buffer and drives an overflow. Six is not a power of two, so the pointer wrap by comparison is exercised on both pointers as traffic passes the end of storage. Keeping SLIP at its default checks the two-byte allowance exactly as it would behave at full size.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

  // Strobes from the control to the storage datapath
  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
  } fifoCmd_t;

endpackage

// File: rtl/rxfb_store.sv
module rxfb_store
  import rxfb_pkg::*;
#(
  parameter int DEPTH  = 576,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fifoCmd_t                    cmd,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  output logic [$clog2(DEPTH+1)-1:0]  level
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrNext, rdNext;

  // Pointer advance: free wrap for power-of-two depth, compare otherwise
  generate
    if (DEPTH == (1 << PTR_W)) begin : g_pow2
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrNext;
      if (cmd.pop)  rdPtr <= rdNext;
      if (cmd.push && !cmd.pop)      level <= level + LVL_W'(1);
      else if (cmd.pop && !cmd.push) level <= level - LVL_W'(1);
    end
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/rxfb_ctrl.sv
module rxfb_ctrl
  import rxfb_pkg::*;
#(
  parameter int DEPTH     = 576,
  parameter int WATERMARK = 383,
  parameter int SLIP      = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hwFlowEn,
  input  logic                        flush,
  input  logic                        wrValid,
  input  logic                        rdReady,
  input  logic [$clog2(DEPTH+1)-1:0]  level,
  input  logic                        ctsN,
  input  logic                        txReq,
  output fifoCmd_t                    cmd,
  output logic                        rdValid,
  output logic                        overflow,
  output logic                        rtsN,
  output logic                        txGrant
);

  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam int SLIP_W = $clog2(SLIP + 1) > 0 ? $clog2(SLIP + 1) : 1;

  logic              full;
  logic              dropWrite;
  logic [SLIP_W-1:0] slipCnt;
  logic              slipOpen;

  // Receive side
  assign full      = (level == LVL_W'(DEPTH));
  assign rdValid   = (level != '0);
  assign cmd.clear = flush;
  assign cmd.pop   = rdValid && rdReady && !flush;
  assign cmd.push  = wrValid && !flush && (!full || cmd.pop);
  assign dropWrite = wrValid && !flush && full && !cmd.pop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          overflow <= 1'b0;
    else if (flush)     overflow <= 1'b0;
    else if (dropWrite) overflow <= 1'b1;
  end

  assign rtsN = hwFlowEn && (level >= LVL_W'(WATERMARK));

  // Transmit gate: count grants issued while the far end is not clear
  assign slipOpen = (slipCnt < SLIP_W'(SLIP));
  assign txGrant  = txReq && (!hwFlowEn || !ctsN || slipOpen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            slipCnt <= '0;
    else if (flush || !hwFlowEn || !ctsN) slipCnt <= '0;
    else if (txGrant && slipOpen)         slipCnt <= slipCnt + SLIP_W'(1);
  end

endmodule

// File: rtl/rx_flow_buffer.sv
module rx_flow_buffer
  import rxfb_pkg::*;
#(
  parameter int DEPTH     = 576,
  parameter int WATERMARK = 383,
  parameter int SLIP      = 2,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hwFlowEn,
  input  logic                        flush,
  input  logic                        wrValid,
  input  logic [DATA_W-1:0]           wrData,
  output logic                        rdValid,
  input  logic                        rdReady,
  output logic [DATA_W-1:0]           rdData,
  output logic [$clog2(DEPTH+1)-1:0]  fillLevel,
  output logic                        overflow,
  output logic                        rtsN,
  input  logic                        ctsN,
  input  logic                        txReq,
  output logic                        txGrant
);

  fifoCmd_t cmd;

  rxfb_ctrl #(
    .DEPTH(DEPTH), .WATERMARK(WATERMARK), .SLIP(SLIP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hwFlowEn(hwFlowEn), .flush(flush),
    .wrValid(wrValid), .rdReady(rdReady), .level(fillLevel),
    .ctsN(ctsN), .txReq(txReq), .cmd(cmd), .rdValid(rdValid),
    .overflow(overflow), .rtsN(rtsN), .txGrant(txGrant)
  );

  rxfb_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .rdData(rdData), .level(fillLevel)
  );

endmodule

// File: rtl/rx_flow_buffer_chk.sv
module rx_flow_buffer_chk #(
  parameter int DEPTH     = 576,
  parameter int WATERMARK = 383,
  parameter int SLIP      = 2,
  parameter int DATA_W    = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        hwFlowEn,
  input logic                        flush,
  input logic                        wrValid,
  input logic [DATA_W-1:0]           wrData,
  input logic                        rdValid,
  input logic                        rdReady,
  input logic [DATA_W-1:0]           rdData,
  input logic [$clog2(DEPTH+1)-1:0]  fillLevel,
  input logic                        overflow,
  input logic                        rtsN,
  input logic                        ctsN,
  input logic                        txReq,
  input logic                        txGrant
);

  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(SLIP + 2);

  // Independent count of grants given while the far end is not clear
  logic [CNT_W-1:0] seenSlip;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            seenSlip <= '0;
    else if (flush || !hwFlowEn || !ctsN) seenSlip <= '0;
    else if (txGrant && seenSlip <= CNT_W'(SLIP)) seenSlip <= seenSlip + CNT_W'(1);
  end

  assert_slip_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (hwFlowEn && ctsN && txGrant) |-> (seenSlip < CNT_W'(SLIP)));

  assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |-> txReq);

  assert_clear_grant_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && hwFlowEn && !ctsN) |-> txGrant);

  assert_disabled_pins_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hwFlowEn |-> (!rtsN && (txGrant == txReq)));

  assert_rts_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hwFlowEn && !flush && wrValid && !rdReady && fillLevel == LVL_W'(WATERMARK - 1))
      |=> (rtsN || !hwFlowEn));

  assert_rts_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady && !wrValid && fillLevel == LVL_W'(WATERMARK)) |=> !rtsN);

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LVL_W'(DEPTH));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !flush) |=> overflow);

  assert_simul_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && rdValid && rdReady && !flush) |=> ($stable(fillLevel) && !$rose(overflow)));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (fillLevel == '0 && !overflow && !rdValid));

  assert_valid_tracks_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == (fillLevel != '0));

endmodule

bind rx_flow_buffer rx_flow_buffer_chk #(
  .DEPTH(DEPTH), .WATERMARK(WATERMARK), .SLIP(SLIP), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_rx_flow_buffer.sv
`timescale 1ns/1ps
module tb_rx_flow_buffer;

  localparam int DEPTH = 6;
  localparam int WM    = 4;
  localparam int SLIP  = 2;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hwFlowEn = 1'b0, flush = 1'b0, wrValid = 1'b0, rdReady = 1'b0;
  logic ctsN = 1'b0, txReq = 1'b0;
  logic [7:0] wrData = '0;
  logic rdValid, overflow, rtsN, txGrant;
  logic [7:0] rdData;
  logic [LVL_W-1:0] fillLevel;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rx_flow_buffer #(.DEPTH(DEPTH), .WATERMARK(WM), .SLIP(SLIP), .DATA_W(8)) dut (
    .clk(clk), .rstN(rstN), .hwFlowEn(hwFlowEn), .flush(flush),
    .wrValid(wrValid), .wrData(wrData), .rdValid(rdValid), .rdReady(rdReady),
    .rdData(rdData), .fillLevel(fillLevel), .overflow(overflow), .rtsN(rtsN),
    .ctsN(ctsN), .txReq(txReq), .txGrant(txGrant)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Hold inputs through one rising edge, return at the next falling edge
  task automatic tick(input logic wv, input logic [7:0] wd, input logic rr);
    wrValid = wv; wrData = wd; rdReady = rr;
    @(negedge clk);
    wrValid = 1'b0; rdReady = 1'b0;
  endtask

  task automatic pushB(input logic [7:0] b);
    tick(1'b1, b, 1'b0);
  endtask

  task automatic popChk(input string req, input logic [7:0] exp);
    #1;
    chk(req, "rdValid", int'(rdValid), 1);
    chk(req, "rdData", int'(rdData), int'(exp));
    tick(1'b0, 8'h00, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1", "fillLevel", int'(fillLevel), 0);
    chk("R1", "rdValid", int'(rdValid), 0);
    chk("R1", "overflow", int'(overflow), 0);
    chk("R1", "rtsN", int'(rtsN), 0);
  endtask

  task automatic t_order();
    hwFlowEn = 1'b0;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 3; i++) pushB(8'(8'h10 * r + i + 1));
      chk("R2", "fillLevel", int'(fillLevel), 3);
      for (int i = 0; i < 3; i++) popChk("R2", 8'(8'h10 * r + i + 1));
    end
    chk("R2", "rdValid empty", int'(rdValid), 0);
  endtask

  task automatic t_watermark();
    hwFlowEn = 1'b1;
    for (int i = 0; i < WM - 1; i++) pushB(8'(8'h20 + i));
    chk("R3", "rtsN below mark", int'(rtsN), 0);
    pushB(8'h2F);
    chk("R3", "fillLevel", int'(fillLevel), WM);
    chk("R3", "rtsN at mark", int'(rtsN), 1);
    popChk("R4", 8'h20);
    chk("R4", "rtsN below mark again", int'(rtsN), 0);
    popChk("R4", 8'h21);
    popChk("R4", 8'h22);
    popChk("R4", 8'h2F);
  endtask

  task automatic t_full();
    hwFlowEn = 1'b1;
    for (int i = 0; i < DEPTH; i++) pushB(8'(8'h40 + i));
    chk("R5", "overflow before drop", int'(overflow), 0);
    pushB(8'h99);
    chk("R5", "fillLevel full", int'(fillLevel), DEPTH);
    chk("R5", "overflow set", int'(overflow), 1);
    for (int i = 0; i < DEPTH; i++) popChk("R5", 8'(8'h40 + i));
    chk("R5", "overflow sticky", int'(overflow), 1);
    chk("R5", "rdValid after drain", int'(rdValid), 0);
    flush = 1'b1; @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_simul();
    pushB(8'hA0); pushB(8'hA1); pushB(8'hA2);
    #1 chk("R6", "rdData before", int'(rdData), 8'hA0);
    tick(1'b1, 8'hA3, 1'b1);
    chk("R6", "fillLevel kept", int'(fillLevel), 3);
    pushB(8'hA4); pushB(8'hA5); pushB(8'hA6);
    #1 chk("R6", "rdData full", int'(rdData), 8'hA1);
    tick(1'b1, 8'hA7, 1'b1);
    chk("R6", "fillLevel full kept", int'(fillLevel), DEPTH);
    chk("R6", "no overflow", int'(overflow), 0);
    for (int i = 2; i < 8; i++) popChk("R6", 8'(8'hA0 + i));
  endtask

  task automatic t_cts();
    hwFlowEn = 1'b1; ctsN = 1'b0; txReq = 1'b1;
    #1 chk("R8", "grant while clear", int'(txGrant), 1);
    @(negedge clk);
    ctsN = 1'b1;
    #1 chk("R7", "slip grant 1", int'(txGrant), 1);
    @(negedge clk);
    #1 chk("R7", "slip grant 2", int'(txGrant), 1);
    @(negedge clk);
    #1 chk("R7", "blocked after slip", int'(txGrant), 0);
    @(negedge clk);
    #1 chk("R7", "still blocked", int'(txGrant), 0);
    ctsN = 1'b0;
    #1 chk("R8", "grant on clear", int'(txGrant), 1);
    txReq = 1'b0;
    #1 chk("R8", "no grant without req", int'(txGrant), 0);
    @(negedge clk);
  endtask

  task automatic t_disabled();
    hwFlowEn = 1'b0; ctsN = 1'b1; txReq = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1 chk("R9", "grant ignores cts", int'(txGrant), 1);
      pushB(8'(8'h60 + i));
    end
    chk("R9", "fillLevel", int'(fillLevel), 5);
    chk("R9", "rtsN held low", int'(rtsN), 0);
    txReq = 1'b0;
  endtask

  task automatic t_flush();
    hwFlowEn = 1'b1;
    pushB(8'h65);
    pushB(8'h77);
    chk("R10", "overflow before flush", int'(overflow), 1);
    chk("R10", "rtsN before flush", int'(rtsN), 1);
    ctsN = 1'b1; txReq = 1'b1;
    @(negedge clk); @(negedge clk);
    #1 chk("R10", "slip exhausted", int'(txGrant), 0);
    flush = 1'b1;
    tick(1'b1, 8'h88, 1'b0);
    flush = 1'b0;
    chk("R10", "fillLevel", int'(fillLevel), 0);
    chk("R10", "overflow cleared", int'(overflow), 0);
    chk("R10", "rdValid", int'(rdValid), 0);
    chk("R10", "rtsN", int'(rtsN), 0);
    #1 chk("R10", "slip restored", int'(txGrant), 1);
    txReq = 1'b0; ctsN = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_watermark();
    t_full();
    t_simul();
    t_cts();
    t_disabled();
    t_flush();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule